// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block sits between the configuration registers of a clock synthesiser and its PLL and dividers. It decides which frequency setting is in force and presents the divider controls. The setting comes from one of three places. The first is a 5-bit frequency code read from board straps. The second is a 5-bit code written by software. The third is a direct programme of the feedback and reference divisors, where the VCO runs at ref × (N+4)/M.

The straps and a current-mode strap share their pins with other functions. A single shared input serves first as the power-good strobe. The block captures the straps once, on the first rise of that input after reset. From then on the same input is read as an active-low power-down request.

A watchdog timeout event overrides the software choices. It turns off direct divisor programming. It also forces the table index to either the strapped code or a programmed safe code. That index holds until software next writes the frequency-select fields.

A 3-bit ratio code selects the VCO-to-output divide ratios for the CPU, 66 MHz and PCI clocks. An unsupported ratio code is rejected and flagged.

Top module: `clk_src_select`

## Requirements
- R1: After reset: activeIdx = 0, useMn = 0, mDiv = 0, nDiv = 0, ratios CPU/66/PCI = 2/4/8, strapsValid = 0, strapReadback = 0, powerDown = 0, ratioErr = 0.
- R2: On the first clock edge at which pwrGoodPdN is high after reset, strapFs and strapMode are captured. From the next cycle strapsValid = 1 and strapReadback = {strapMode, strapFs}, with bit 5 holding the mode strap and bits 4..0 holding the frequency code.
- R3: Once captured, the strap values never change again until reset. Later strap pin changes and later rises of pwrGoodPdN are ignored.
- R4: powerDown is 1 exactly one cycle after an edge at which straps are already captured and pwrGoodPdN is low. Before capture, a low pwrGoodPdN leaves powerDown at 0.
- R5: A wrFreq pulse loads wrSwSelEn and wrSwCode. With no watchdog override in force, activeIdx equals the software code when the enable is 1, and the captured strap code when it is 0.
- R6: A wrMn pulse loads mDiv from wrM and nDiv from wrN, and sets useMn to wrMnEn. All three are visible the next cycle.
- R7: A wrMn pulse with a valid wrRatio sets cpuRatio/r66Ratio/pciRatio as follows: 0→2/4/8, 1→2/5/10, 2→2/6/12, 3→3/6/12, 4→4/4/8, 5→4/6/12, 6→6/6/12.
- R8: A wrMn pulse with wrRatio = 7 leaves all three ratios unchanged and sets ratioErr. ratioErr stays set until a wrMn pulse carries a valid ratio code.
- R9: A wdTimeout pulse clears useMn. It forces activeIdx to safeCode if safeReloadEn is 1, or to the captured strap code if it is 0. The forced index holds until the next accepted wrFreq.
- R10: When wdTimeout and wrFreq arrive in the same cycle, the timeout wins. The override takes effect and the software fields are left unchanged. The same holds for the useMn enable when wdTimeout and wrMn coincide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrGoodPdN | input | 1 | Power-good strobe until straps are captured, then active-low power-down |
| strapFs | input | 5 | Frequency-select strap pins |
| strapMode | input | 1 | Current-mode strap pin |
| wrFreq | input | 1 | Write pulse for the software select fields |
| wrSwSelEn | input | 1 | Software-select enable value |
| wrSwCode | input | 5 | Software frequency code value |
| wrMn | input | 1 | Write pulse for the divisor and ratio fields |
| wrMnEn | input | 1 | Direct divisor programming enable value |
| wrM | input | 5 | M divisor value |
| wrN | input | 9 | N divisor value |
| wrRatio | input | 3 | Ratio code value |
| safeReloadEn | input | 1 | Timeout reloads safeCode (1) or straps (0) |
| safeCode | input | 5 | Safe frequency code |
| wdTimeout | input | 1 | Watchdog timeout event pulse |
| activeIdx | output | 5 | Active frequency table index |
| useMn | output | 1 | 1 = divisors drive the PLL, 0 = table |
| mDiv | output | 5 | M divisor |
| nDiv | output | 9 | N divisor |
| cpuRatio | output | 4 | VCO-to-CPU divide ratio |
| r66Ratio | output | 4 | VCO-to-66 MHz divide ratio |
| pciRatio | output | 4 | VCO-to-PCI divide ratio |
| strapReadback | output | 6 | Captured {mode, frequency code} |
| strapsValid | output | 1 | Straps have been captured |
| powerDown | output | 1 | Power-down request |
| ratioErr | output | 1 | Last ratio write carried an unsupported code |

## Verification
The hardest situations to reach are those where the shared pin changes role, and where a watchdog event collides with a software write. The stimulus first holds the pin low before capture and checks that no power-down appears. It then captures the straps, changes the strap pins and pulses the pin again, and checks that the readback and the index do not move. Timeouts are issued under both reload choices, and one is driven in the same cycle as a frequency write, so that the winner is visible on activeIdx.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int FS_W    = 5;
  localparam int M_W     = 5;
  localparam int N_W     = 9;
  localparam int RCODE_W = 3;
  localparam int DIV_W   = 4;
  localparam logic [RCODE_W-1:0] BAD_RCODE = '1;

  typedef struct packed {
    logic capStraps;
    logic takeTimeout;
    logic takeFreq;
    logic takeMn;
    logic takeRatio;
    logic badRatio;
  } strobe_t;

  typedef struct packed {
    logic [DIV_W-1:0] cpu;
    logic [DIV_W-1:0] r66;
    logic [DIV_W-1:0] pci;
  } ratio_t;

  function automatic ratio_t decodeRatio(input logic [RCODE_W-1:0] code);
    ratio_t r;
    r.cpu = (code[2] == 1'b0) ? ((code[1:0] == 2'b11) ? 4'd3 : 4'd2)
                              : ((code[1] == 1'b1) ? 4'd6 : 4'd4);
    case (code)
      3'd0, 3'd4: r.r66 = 4'd4;
      3'd1:       r.r66 = 4'd5;
      default:    r.r66 = 4'd6;
    endcase
    r.pci = r.r66 << 1;
    return r;
  endfunction
endpackage

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
  import clk_src_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwrGoodPdN,
  input  logic                 wrFreq,
  input  logic                 wrMn,
  input  logic [RCODE_W-1:0]   wrRatio,
  input  logic                 wdTimeout,
  output strobe_t              strobes,
  output logic                 strapsValid,
  output logic                 powerDown
);
  logic capturedQ;
  logic powerDownQ;

  always_comb begin
    strobes.capStraps   = pwrGoodPdN & ~capturedQ;
    strobes.takeTimeout = wdTimeout;
    strobes.takeFreq    = wrFreq & ~wdTimeout;
    strobes.takeMn      = wrMn;
    strobes.takeRatio   = wrMn & (wrRatio != BAD_RCODE);
    strobes.badRatio    = wrMn & (wrRatio == BAD_RCODE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capturedQ  <= 1'b0;
      powerDownQ <= 1'b0;
    end else begin
      if (strobes.capStraps) capturedQ <= 1'b1;
      powerDownQ <= capturedQ & ~pwrGoodPdN;
    end
  end

  assign strapsValid = capturedQ;
  assign powerDown   = powerDownQ;
endmodule

// File: rtl/clk_src_datapath.sv
module clk_src_datapath
  import clk_src_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strobes,
  input  logic [FS_W-1:0]      strapFs,
  input  logic                 strapMode,
  input  logic                 wrSwSelEn,
  input  logic [FS_W-1:0]      wrSwCode,
  input  logic                 wrMnEn,
  input  logic [M_W-1:0]       wrM,
  input  logic [N_W-1:0]       wrN,
  input  logic [RCODE_W-1:0]   wrRatio,
  input  logic                 safeReloadEn,
  input  logic [FS_W-1:0]      safeCode,
  output logic [FS_W-1:0]      activeIdx,
  output logic                 useMn,
  output logic [M_W-1:0]       mDiv,
  output logic [N_W-1:0]       nDiv,
  output ratio_t               ratios,
  output logic [FS_W:0]        strapReadback,
  output logic                 ratioErr
);
  logic [FS_W-1:0]    strapFsQ;
  logic               strapModeQ;
  logic               swSelEnQ;
  logic [FS_W-1:0]    swCodeQ;
  logic               overrideQ;
  logic [FS_W-1:0]    wdCodeQ;
  logic               mnEnQ;
  logic [M_W-1:0]     mQ;
  logic [N_W-1:0]     nQ;
  logic [RCODE_W-1:0] ratioCodeQ;
  logic               ratioErrQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strapFsQ   <= '0;
      strapModeQ <= 1'b0;
    end else if (strobes.capStraps) begin
      strapFsQ   <= strapFs;
      strapModeQ <= strapMode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swSelEnQ  <= 1'b0;
      swCodeQ   <= '0;
      overrideQ <= 1'b0;
      wdCodeQ   <= '0;
    end else if (strobes.takeTimeout) begin
      overrideQ <= 1'b1;
      wdCodeQ   <= safeReloadEn ? safeCode : strapFsQ;
    end else if (strobes.takeFreq) begin
      overrideQ <= 1'b0;
      swSelEnQ  <= wrSwSelEn;
      swCodeQ   <= wrSwCode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mnEnQ <= 1'b0;
      mQ    <= '0;
      nQ    <= '0;
    end else begin
      if (strobes.takeMn) begin
        mQ <= wrM;
        nQ <= wrN;
      end
      if (strobes.takeTimeout)  mnEnQ <= 1'b0;
      else if (strobes.takeMn)  mnEnQ <= wrMnEn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratioCodeQ <= '0;
      ratioErrQ  <= 1'b0;
    end else if (strobes.takeRatio) begin
      ratioCodeQ <= wrRatio;
      ratioErrQ  <= 1'b0;
    end else if (strobes.badRatio) begin
      ratioErrQ  <= 1'b1;
    end
  end

  always_comb begin
    if (overrideQ)     activeIdx = wdCodeQ;
    else if (swSelEnQ) activeIdx = swCodeQ;
    else               activeIdx = strapFsQ;
  end

  assign useMn         = mnEnQ;
  assign mDiv          = mQ;
  assign nDiv          = nQ;
  assign ratios        = decodeRatio(ratioCodeQ);
  assign strapReadback = {strapModeQ, strapFsQ};
  assign ratioErr      = ratioErrQ;
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import clk_src_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwrGoodPdN,
  input  logic [FS_W-1:0]    strapFs,
  input  logic               strapMode,
  input  logic               wrFreq,
  input  logic               wrSwSelEn,
  input  logic [FS_W-1:0]    wrSwCode,
  input  logic               wrMn,
  input  logic               wrMnEn,
  input  logic [M_W-1:0]     wrM,
  input  logic [N_W-1:0]     wrN,
  input  logic [RCODE_W-1:0] wrRatio,
  input  logic               safeReloadEn,
  input  logic [FS_W-1:0]    safeCode,
  input  logic               wdTimeout,
  output logic [FS_W-1:0]    activeIdx,
  output logic               useMn,
  output logic [M_W-1:0]     mDiv,
  output logic [N_W-1:0]     nDiv,
  output logic [DIV_W-1:0]   cpuRatio,
  output logic [DIV_W-1:0]   r66Ratio,
  output logic [DIV_W-1:0]   pciRatio,
  output logic [FS_W:0]      strapReadback,
  output logic               strapsValid,
  output logic               powerDown,
  output logic               ratioErr
);
  strobe_t strobes;
  ratio_t  ratios;

  clk_src_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrGoodPdN(pwrGoodPdN), .wrFreq(wrFreq),
    .wrMn(wrMn), .wrRatio(wrRatio), .wdTimeout(wdTimeout),
    .strobes(strobes), .strapsValid(strapsValid), .powerDown(powerDown)
  );

  clk_src_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .strapFs(strapFs),
    .strapMode(strapMode), .wrSwSelEn(wrSwSelEn), .wrSwCode(wrSwCode),
    .wrMnEn(wrMnEn), .wrM(wrM), .wrN(wrN), .wrRatio(wrRatio),
    .safeReloadEn(safeReloadEn), .safeCode(safeCode),
    .activeIdx(activeIdx), .useMn(useMn), .mDiv(mDiv), .nDiv(nDiv),
    .ratios(ratios), .strapReadback(strapReadback), .ratioErr(ratioErr)
  );

  assign cpuRatio = ratios.cpu;
  assign r66Ratio = ratios.r66;
  assign pciRatio = ratios.pci;
endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwrGoodPdN,
  input logic       wrMn,
  input logic       wrMnEn,
  input logic [2:0] wrRatio,
  input logic       wrFreq,
  input logic       wdTimeout,
  input logic       safeReloadEn,
  input logic [4:0] safeCode,
  input logic [4:0] activeIdx,
  input logic       useMn,
  input logic [3:0] cpuRatio,
  input logic [5:0] strapReadback,
  input logic       strapsValid,
  input logic       powerDown,
  input logic       ratioErr
);
  // R3
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strapsValid |=> $stable(strapReadback));

  // R2
  capture_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strapsValid && pwrGoodPdN) |=> strapsValid);

  // R4
  pd_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    powerDown |-> strapsValid);

  // R8
  bad_ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrMn && wrRatio == 3'd7) |=> ($stable(cpuRatio) && ratioErr));

  // R9
  timeout_clears_mn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdTimeout |=> !useMn);

  // R9
  safe_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdTimeout && safeReloadEn) |=> (activeIdx == $past(safeCode)));

  // R6
  mn_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrMn && !wdTimeout) |=> (useMn == $past(wrMnEn)));
endmodule

bind clk_src_select clk_src_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwrGoodPdN(pwrGoodPdN), .wrMn(wrMn),
  .wrMnEn(wrMnEn), .wrRatio(wrRatio), .wrFreq(wrFreq), .wdTimeout(wdTimeout),
  .safeReloadEn(safeReloadEn), .safeCode(safeCode), .activeIdx(activeIdx),
  .useMn(useMn), .cpuRatio(cpuRatio), .strapReadback(strapReadback),
  .strapsValid(strapsValid), .powerDown(powerDown), .ratioErr(ratioErr)
);

// File: tb/clk_src_select_test.sv
module clk_src_select_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrGoodPdN = 1'b0;
  logic [4:0] strapFs = '0;
  logic strapMode = 1'b0;
  logic wrFreq = 1'b0, wrSwSelEn = 1'b0;
  logic [4:0] wrSwCode = '0;
  logic wrMn = 1'b0, wrMnEn = 1'b0;
  logic [4:0] wrM = '0;
  logic [8:0] wrN = '0;
  logic [2:0] wrRatio = '0;
  logic safeReloadEn = 1'b0;
  logic [4:0] safeCode = '0;
  logic wdTimeout = 1'b0;
  logic [4:0] activeIdx;
  logic useMn;
  logic [4:0] mDiv;
  logic [8:0] nDiv;
  logic [3:0] cpuRatio, r66Ratio, pciRatio;
  logic [5:0] strapReadback;
  logic strapsValid, powerDown, ratioErr;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_src_select uut (.*);

  // {code, cpu, r66, pci}
  localparam logic [14:0] RATIO_VEC [7] = '{
    {3'd3, 4'd3, 4'd6, 4'd12},
    {3'd1, 4'd2, 4'd5, 4'd10},
    {3'd6, 4'd6, 4'd6, 4'd12},
    {3'd0, 4'd2, 4'd4, 4'd8},
    {3'd5, 4'd4, 4'd6, 4'd12},
    {3'd2, 4'd2, 4'd6, 4'd12},
    {3'd4, 4'd4, 4'd4, 4'd8}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeFreq(input logic en, input logic [4:0] code);
    wrFreq = 1'b1; wrSwSelEn = en; wrSwCode = code;
    tick();
    wrFreq = 1'b0;
  endtask

  task automatic writeMn(input logic en, input logic [4:0] m, input logic [8:0] n,
                         input logic [2:0] r);
    wrMn = 1'b1; wrMnEn = en; wrM = m; wrN = n; wrRatio = r;
    tick();
    wrMn = 1'b0;
  endtask

  task automatic timeout(input logic safeEn, input logic [4:0] code);
    wdTimeout = 1'b1; safeReloadEn = safeEn; safeCode = code;
    tick();
    wdTimeout = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idx", activeIdx, 0);
    check("R1 useMn", useMn, 0);
    check("R1 cpu", cpuRatio, 2);
    check("R1 r66", r66Ratio, 4);
    check("R1 pci", pciRatio, 8);
    check("R1 valid", strapsValid, 0);
    check("R1 err", ratioErr, 0);
    rst_n = 1'b1;
    strapFs = 5'b10110; strapMode = 1'b1;
    tick(); tick();
    // R4 low pin before capture is not power-down
    check("R4 pre-capture", powerDown, 0);
    check("R2 not yet valid", strapsValid, 0);
    pwrGoodPdN = 1'b1;
    tick();
    // R2 capture
    check("R2 valid", strapsValid, 1);
    check("R2 readback", strapReadback, 6'b110110);
    check("R5 strap idx", activeIdx, 22);
    // R3 later pin activity ignored
    strapFs = 5'b01001; strapMode = 1'b0;
    pwrGoodPdN = 1'b0;
    tick();
    check("R4 pd", powerDown, 1);
    pwrGoodPdN = 1'b1;
    tick();
    check("R4 pd release", powerDown, 0);
    check("R3 readback", strapReadback, 6'b110110);
    check("R3 idx", activeIdx, 22);
    // R5 software select
    writeFreq(1'b1, 5'd3);
    check("R5 sw idx", activeIdx, 3);
    writeFreq(1'b0, 5'd3);
    check("R5 back to strap", activeIdx, 22);
    // R7 ratio table
    for (int i = 0; i < 7; i++) begin
      writeMn(1'b0, 5'd0, 9'd0, RATIO_VEC[i][14:12]);
      check("R7 cpu", cpuRatio, int'(RATIO_VEC[i][11:8]));
      check("R7 r66", r66Ratio, int'(RATIO_VEC[i][7:4]));
      check("R7 pci", pciRatio, int'(RATIO_VEC[i][3:0]));
    end
    // R8 bad code
    writeMn(1'b0, 5'd0, 9'd0, 3'd5);
    writeMn(1'b0, 5'd0, 9'd0, 3'd7);
    check("R8 cpu held", cpuRatio, 4);
    check("R8 r66 held", r66Ratio, 6);
    check("R8 pci held", pciRatio, 12);
    check("R8 err", ratioErr, 1);
    tick();
    check("R8 err sticky", ratioErr, 1);
    writeMn(1'b0, 5'd0, 9'd0, 3'd0);
    check("R8 err clear", ratioErr, 0);
    // R6 divisor programme
    writeMn(1'b1, 5'd7, 9'd300, 3'd0);
    check("R6 useMn", useMn, 1);
    check("R6 m", mDiv, 7);
    check("R6 n", nDiv, 300);
    // R9 timeout with safe reload
    writeFreq(1'b1, 5'd4);
    timeout(1'b1, 5'd30);
    check("R9 useMn cleared", useMn, 0);
    check("R9 safe idx", activeIdx, 30);
    tick();
    check("R9 held", activeIdx, 30);
    timeout(1'b0, 5'd30);
    check("R9 strap idx", activeIdx, 22);
    writeFreq(1'b1, 5'd5);
    check("R9 released", activeIdx, 5);
    // R10 collisions
    wrFreq = 1'b1; wrSwSelEn = 1'b1; wrSwCode = 5'd9;
    timeout(1'b1, 5'd7);
    wrFreq = 1'b0;
    check("R10 timeout wins", activeIdx, 7);
    writeFreq(1'b0, 5'd0);
    check("R10 sw fields kept", activeIdx, 22);
    wrMn = 1'b1; wrMnEn = 1'b1; wrM = 5'd3; wrN = 9'd1; wrRatio = 3'd0;
    timeout(1'b1, 5'd1);
    wrMn = 1'b0;
    check("R10 mn off", useMn, 0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule